// File: doc/BRIEF.md
# PCM Codec Serial Port

This block is the digital serial interface of a telephony voice codec. Each frame it sends one 8-bit companded word and receives another. A word is a sign bit, then the chord bits, then the step bits, and it always travels most significant bit first. The transmit direction follows its own bit clock and frame sync. The receive direction follows a separate bit clock and frame sync. A single mode input chooses how frame sync is read for both directions, either long-frame or short-frame.

All serial inputs are sampled by a fast system clock, and edges are found by comparing each sample with the one before it. The bit clock is therefore an oversampled signal, not a clock net. In long-frame mode a frame starts at the later of two edges: the frame sync rising or the bit clock rising. In short-frame mode a one-period sync pulse is read on a falling bit-clock edge, and the word starts on the next rising edge. The transmit pin is not bidirectional. Instead, the block provides a data output and an output-enable. A pad cell uses the enable to drive the line or leave it high-impedance.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is asserted and directly after it, `txOe` is 0, `txData` is 0, `rxValid` is 0 and `rxWord` is 0.
- R2: A transmitted word leaves MSB first, one bit per bit-clock period, over exactly 8 periods. Bits after the MSB change only on rising edges of `txBclk`. While `txOe` is 0, `txData` is 0.
- R3: Long-frame mode (`frameMode`=0). The frame starts and the MSB is driven at the later of two edges: `txFs` rising or `txBclk` rising. A sync that rises while the bit clock is low does not drive the line on its own.
- R4: Long-frame mode. `txOe` falls at the later of the 8th falling edge of `txBclk` and the falling edge of `txFs`. A sync still high after the 8th fall keeps the line driven until the sync falls.
- R5: Short-frame mode (`frameMode`=1). A sync level that is high at a falling bit-clock edge arms a frame. The MSB is then driven at the next rising edge.
- R6: Short-frame mode. `txOe` falls at the 8th falling edge of `txBclk`, whatever the sync level is.
- R7: Received bits are taken on falling edges of `rxBclk`, MSB first. After the 8th bit, `rxWord` holds the word and `rxValid` is high for exactly one clock.
- R8: A new frame start while a frame is in progress discards the partial word. No `rxValid` is produced for it, and both directions restart at bit 0. In short-frame mode, a new sync pulse does this.
- R9: All inputs are treated as synchronous to `clk`. An output responds on the first `clk` edge at which the new input level is sampled.
- R10: `txWord` is captured at the frame start. Changing it later in the frame does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples every serial input |
| rstN | input | 1 | Asynchronous active-low reset |
| frameMode | input | 1 | 0 = long-frame sync, 1 = short-frame sync |
| txWord | input | 8 | Word to send in the next transmit frame |
| txBclk | input | 1 | Transmit bit clock |
| txFs | input | 1 | Transmit frame sync |
| txData | output | 1 | Serial transmit data, 0 when not driven |
| txOe | output | 1 | Pad enable; 0 means the line is high-impedance |
| rxBclk | input | 1 | Receive bit clock |
| rxFs | input | 1 | Receive frame sync |
| rxData | input | 1 | Serial receive data |
| rxWord | output | 8 | Last complete received word |
| rxValid | output | 1 | One-clock strobe when `rxWord` is updated |

## Verification
Long frames are run in two ways. In one, the sync rises while the bit clock is low, so the clock edge launches the MSB. In the other, the sync rises during a high phase, so the sync edge launches it. This separates the two branches of the "later edge" rule. Sync widths of two, three and ten periods check whether the line is released by the 8th fall or by the sync fall. Short frames cover a clean word, a `txWord` change partway through a frame, and a second sync pulse after four bits, which must discard the partial receive word. Loopback of transmit into receive confirms that the launch and capture edges agree. Frames with an independent receive pattern confirm that the receive direction does not depend on the transmit data.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    SYNC_LONG  = 1'b0,
    SYNC_SHORT = 1'b1
  } syncMode_e;

  // Strobes from the frame control to a data path, valid for one clk
  typedef struct packed {
    logic start;   // frame begins: load word / reset bit position
    logic shift;   // rising bit-clock edge inside the frame, bits 2..8
    logic sample;  // falling bit-clock edge inside the frame
    logic finish;  // falling edge that closes the 8th bit period
  } pcmStrobe_t;

endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameMode,
  input  logic       bitClk,
  input  logic       frameSync,
  output pcmStrobe_t stb
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  logic             bitClkQ;
  logic             syncSeen;   // long mode: this sync level already began a frame
  logic             syncArmed;  // short mode: sync seen on a falling edge
  logic             active;
  logic [CNT_W-1:0] bitCnt;

  logic bRise, bFall, longStart, shortStart;

  always_comb begin
    bRise      = bitClk & ~bitClkQ;
    bFall      = ~bitClk & bitClkQ;
    longStart  = (frameMode == SYNC_LONG) & frameSync & bitClk & ~syncSeen;
    shortStart = (frameMode == SYNC_SHORT) & bRise & syncArmed;
    stb.start  = longStart | shortStart;
    stb.shift  = active & bRise & ~stb.start & (bitCnt != '0);
    stb.sample = active & bFall & ~stb.start;
    stb.finish = stb.sample & (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkQ   <= 1'b0;
      syncSeen  <= 1'b0;
      syncArmed <= 1'b0;
      active    <= 1'b0;
      bitCnt    <= '0;
    end else begin
      bitClkQ <= bitClk;

      if (!frameSync)     syncSeen <= 1'b0;
      else if (longStart) syncSeen <= 1'b1;

      if (shortStart)                             syncArmed <= 1'b0;
      else if ((frameMode == SYNC_SHORT) && bFall) syncArmed <= frameSync;

      if (stb.start) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (stb.sample) begin
        if (stb.finish) active <= 1'b0;
        else            bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !active); // R2

  AST_START_RESETS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (active && bitCnt == '0)); // R8

  AST_NO_SHIFT_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.shift && stb.sample)); // R2

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameMode,
  input  logic                 frameSync,
  input  pcmStrobe_t           stb,
  input  logic [WORD_BITS-1:0] txWord,
  output logic                 txData,
  output logic                 txOe
);

  logic [WORD_BITS-1:0] shiftReg;
  logic                 holdTail;  // long mode: bits done, sync still high

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txOe     <= 1'b0;
      holdTail <= 1'b0;
    end else if (stb.start) begin
      shiftReg <= txWord;
      txOe     <= 1'b1;
      holdTail <= 1'b0;
    end else begin
      if (stb.shift) shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b0};
      if (stb.finish) begin
        if ((frameMode == SYNC_SHORT) || !frameSync) txOe <= 1'b0;
        else                                         holdTail <= 1'b1;
      end else if (holdTail && !frameSync) begin
        txOe     <= 1'b0;
        holdTail <= 1'b0;
      end
    end
  end

  assign txData = txOe & shiftReg[WORD_BITS-1];

  AST_DRIVE_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> txOe); // R3

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txOe && !stb.start && !stb.shift) |=> (!txOe || $stable(txData))); // R2

  AST_SHORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (frameMode == SYNC_SHORT && stb.finish) |=> !txOe); // R6

  AST_LONG_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (frameMode == SYNC_LONG && stb.finish && frameSync) |=> txOe); // R4

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> !txData); // R2

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pcmStrobe_t           stb,
  input  logic                 rxData,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.sample) shiftReg <= {shiftReg[WORD_BITS-2:0], rxData};
      if (stb.finish) begin
        rxWord  <= {shiftReg[WORD_BITS-2:0], rxData};
        rxValid <= 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.start, stb.shift, stb.sample})); // R7

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(rxWord)); // R7

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameMode,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 txBclk,
  input  logic                 txFs,
  output logic                 txData,
  output logic                 txOe,
  input  logic                 rxBclk,
  input  logic                 rxFs,
  input  logic                 rxData,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid
);

  pcmStrobe_t txStb, rxStb;

  pcm_frame_ctrl #(.WORD_BITS(WORD_BITS)) u_txCtrl (
    .clk(clk), .rstN(rstN), .frameMode(frameMode),
    .bitClk(txBclk), .frameSync(txFs), .stb(txStb)
  );

  pcm_tx_path #(.WORD_BITS(WORD_BITS)) u_txPath (
    .clk(clk), .rstN(rstN), .frameMode(frameMode), .frameSync(txFs),
    .stb(txStb), .txWord(txWord), .txData(txData), .txOe(txOe)
  );

  pcm_frame_ctrl #(.WORD_BITS(WORD_BITS)) u_rxCtrl (
    .clk(clk), .rstN(rstN), .frameMode(frameMode),
    .bitClk(rxBclk), .frameSync(rxFs), .stb(rxStb)
  );

  pcm_rx_path #(.WORD_BITS(WORD_BITS)) u_rxPath (
    .clk(clk), .rstN(rstN), .stb(rxStb), .rxData(rxData),
    .rxWord(rxWord), .rxValid(rxValid)
  );

endmodule

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;

  localparam int HALF = 6;  // clk cycles per bit-clock phase

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameMode;
  logic [7:0] txWord;
  logic       bclk, fs, loop, rxBit;
  logic       txData, txOe, rxValid;
  logic [7:0] rxWord;
  logic       rxData;

  int tests = 0, fails = 0, vCount = 0;
  logic [7:0] lastRx = '0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign rxData = loop ? txData : rxBit;

  pcm_serial_port u_pcm_serial_port (
    .clk(clk), .rstN(rstN), .frameMode(frameMode), .txWord(txWord),
    .txBclk(bclk), .txFs(fs), .txData(txData), .txOe(txOe),
    .rxBclk(bclk), .rxFs(fs), .rxData(rxData),
    .rxWord(rxWord), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   pb, usedSync, armed, inFrame, linger;
  int   periods;
  bit   mData, mOe, mValid;
  logic [7:0] mWord;
  bit   txQ[$];
  bit   rxQ[$];

  always @(posedge clk) begin
    bit rise, fall, go, rin;
    if (!rstN) begin
      pb = 0; usedSync = 0; armed = 0; inFrame = 0; linger = 0; periods = 0;
      mData = 0; mOe = 0; mValid = 0; mWord = '0; txQ = {}; rxQ = {};
    end else begin
      rin  = loop ? mData : rxBit;
      rise = bclk && !pb;
      fall = !bclk && pb;
      go   = 0;
      if (!frameMode) begin
        if (fs && bclk && !usedSync) begin go = 1; usedSync = 1; end
      end else if (rise && armed) begin
        go = 1; armed = 0;
      end
      if (!fs) usedSync = 0;
      if (frameMode && fall) armed = fs;
      mValid = 0;
      if (go) begin
        txQ = {};
        for (int i = 7; i >= 0; i--) txQ.push_back(txWord[i]);
        mData = txQ.pop_front();
        mOe = 1; inFrame = 1; periods = 0; rxQ = {}; linger = 0;
      end else if (inFrame && fall) begin
        rxQ.push_back(rin);
        periods++;
        if (periods == 8) begin
          inFrame = 0; mValid = 1;
          for (int i = 0; i < 8; i++) mWord[7-i] = rxQ[i];
          if (frameMode || !fs) begin mOe = 0; mData = 0; end
          else linger = 1;
        end
      end else begin
        if (inFrame && rise && periods > 0) mData = txQ.pop_front();
        if (linger && !fs) begin linger = 0; mOe = 0; mData = 0; end
      end
      pb = bclk;
    end
    #2;
    check(txData === mData, "R2 txData", txData, mData);
    check(txOe === mOe, "R9 txOe", txOe, mOe);
    check(rxValid === mValid, "R7 rxValid", rxValid, mValid);
    check(rxWord === mWord, "R7 rxWord", rxWord, mWord);
    if (rxValid) begin vCount++; lastRx = rxWord; end
  end

  // ---------------- stimulus ----------------
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(input logic d, input logic s);
    rxBit = d; bclk = 1; waitN(1); fs = s; waitN(HALF - 1);
    bclk = 0; waitN(HALF);
  endtask

  task automatic longFrame(input logic [7:0] w, input bit fsInHigh, input int fsBits,
                           input bit lp, input logic [7:0] rxW);
    frameMode = 0; loop = lp; txWord = w; fs = 0;
    period(0, 0);
    if (!fsInHigh) begin
      fs = 1; waitN(2);
      check(txOe == 0, "R3 sync before clock", txOe, 0);
    end
    for (int p = 0; p < 12; p++) begin
      rxBit = (p < 8) ? rxW[7-p] : 1'b0;
      bclk = 1;
      if (p == 0 && fsInHigh) begin
        waitN(2); check(txOe == 0, "R3 clock before sync", txOe, 0);
        fs = 1; waitN(1); check(txOe == 1, "R3 sync edge launches", txOe, 1);
        waitN(HALF - 3);
      end else if (p == 0) begin
        waitN(1); check(txOe == 1, "R3 clock edge launches", txOe, 1);
        waitN(HALF - 1);
      end else waitN(HALF);
      bclk = 0; waitN(2);
      if (p == 7) check(txOe == (fsBits >= 8), "R4 after 8th fall", txOe, fsBits >= 8);
      waitN(1);
      if (p == fsBits - 1) fs = 0;
      waitN(1);
      if (p == fsBits - 1 && fsBits >= 8) check(txOe == 0, "R4 sync fall releases", txOe, 0);
      waitN(HALF - 4);
    end
    fs = 0; period(0, 0);
  endtask

  task automatic shortFrame(input logic [7:0] w, input logic [7:0] rxA, input logic [7:0] rxB,
                            input bit lp, input int cut, input bit swap);
    int n;
    frameMode = 1; loop = lp; txWord = w; fs = 0;
    period(0, 0);
    period(0, 1);
    n = cut + 8;
    for (int i = 0; i < n; i++) begin
      rxBit = (i < cut) ? rxA[7-i] : rxB[7-(i-cut)];
      bclk = 1;
      if (i == 0) check(txOe == 0, "R9 not yet sampled", txOe, 0);
      waitN(1);
      if (i == 0) check(txOe == 1, "R5 MSB after armed fall", txOe, 1);
      fs = (cut > 0 && i == cut - 1);
      waitN(HALF - 1);
      bclk = 0;
      if (swap && i == 2) txWord = ~w;
      waitN(2);
      if (i == n - 1) check(txOe == 0, "R6 release at 8th fall", txOe, 0);
      waitN(HALF - 2);
    end
    fs = 0; period(0, 0); period(0, 0);
  endtask

  initial begin
    int v0;
    rstN = 0; frameMode = 0; txWord = '0; bclk = 0; fs = 0; loop = 0; rxBit = 0;
    waitN(4);
    check(txOe == 0 && txData == 0, "R1 tx idle in reset", {txOe, txData}, 0);
    check(rxValid == 0 && rxWord == 0, "R1 rx idle in reset", {rxValid, rxWord}, 0);
    rstN = 1; waitN(3);
    check(txOe == 0 && rxValid == 0, "R1 idle after reset", {txOe, rxValid}, 0);

    v0 = vCount; longFrame(8'hA5, 0, 3, 1, 8'h00);
    check(vCount - v0 == 1 && lastRx == 8'hA5, "R2 R3 long loopback", lastRx, 8'hA5);

    v0 = vCount; longFrame(8'h3C, 1, 2, 1, 8'h00);
    check(vCount - v0 == 1 && lastRx == 8'h3C, "R3 R7 sync-in-high loopback", lastRx, 8'h3C);

    v0 = vCount; longFrame(8'h96, 0, 10, 0, 8'h5A);
    check(vCount - v0 == 1 && lastRx == 8'h5A, "R4 R7 long tail rx", lastRx, 8'h5A);

    v0 = vCount; shortFrame(8'hC3, 8'h00, 8'h00, 1, 0, 0);
    check(vCount - v0 == 1 && lastRx == 8'hC3, "R5 short loopback", lastRx, 8'hC3);

    v0 = vCount; shortFrame(8'h71, 8'h00, 8'h00, 1, 0, 1);
    check(lastRx == 8'h71, "R10 word captured at start", lastRx, 8'h71);

    v0 = vCount; shortFrame(8'h0F, 8'hFF, 8'h81, 0, 4, 0);
    check(vCount - v0 == 1, "R8 one valid after restart", vCount - v0, 1);
    check(lastRx == 8'h81, "R8 partial word discarded", lastRx, 8'h81);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule